// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block decides when the core of a small 8-bit microcontroller sleeps, and how it wakes. Software writes a power control register. Bit 0 requests idle and bit 1 requests power-down. Setting a bit with a read-modify-write OR enters that mode on the next clock edge. From the decoded mode the block drives three enables: a CPU clock gate, a peripheral clock enable and an oscillator enable. In idle only the CPU clock stops. In power-down all three drop.

Wake-up depends on the mode. In idle, any interrupt request whose enable is set returns the block to running on the next edge and clears the idle bit. A hardware reset in idle opens a window of two machine cycles. During that window the CPU clock runs, internal RAM writes are blocked and the internal reset is not yet asserted. When the window closes, the internal reset takes over.

In power-down, interrupts are ignored. Only a hardware reset ends the mode. That reset restarts the oscillator at once, and the internal reset stays asserted for a programmable settling count. Any internal reset clears the power control register. RAM contents are not this block's concern.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: A hardware reset seen while running asserts `core_rst` on the next edge and clears `reg_rdata` to 0x00, with `mode_state` reading 001 (running). `core_rst` drops on the first edge at which `hw_rst` is low, so it stays high for as many cycles as `hw_rst` was sampled high.
- R2: Writing a value with bit 0 set and bit 1 clear enters idle on the next edge. `mode_state` reads 010, `cpu_clk_en` is 0, and `periph_clk_en` and `osc_en` are 1.
- R3: Writing a value with bit 1 set enters power-down on the next edge. `mode_state` reads 100 and `cpu_clk_en`, `periph_clk_en` and `osc_en` are all 0.
- R4: A single write that sets both bit 0 and bit 1 enters power-down and stores bit 0 as 0, so `reg_rdata` shows bit 1 set and bit 0 clear.
- R5: In idle, a cycle in which some bit of `irq_req` is high together with the same bit of `irq_en` returns the block to running on the next edge and clears bit 0 of the register. A request whose enable bit is low leaves the block in idle.
- R6: In power-down, enabled interrupt requests have no effect, and the mode stays 100 until `hw_rst` is sampled high.
- R7: A hardware reset seen in idle makes `ram_wr_block` high for exactly CLK_PER_MC*GUARD_MC cycles (24 by default). During that window `cpu_clk_en` is 1 and `core_rst` is 0. On the edge that drops `ram_wr_block`, `core_rst` rises.
- R8: A hardware reset seen in power-down raises `osc_en` and `core_rst` on the next edge. `core_rst` stays high for max(H, OSC_WAIT) cycles, where H is the number of edges at which `hw_rst` was sampled high.
- R9: Register writes take effect only while running with no reset sequence active. Writes made in power-down, during `ram_wr_block` or during `core_rst` leave `reg_rdata` unchanged.
- R10: Register bits 7 to 2 store the written value and read back unchanged.
- R11: `mode_state` is always one-hot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-running reference clock |
| hw_rst | input | 1 | External hardware reset, active high |
| reg_wr | input | 1 | Write strobe for the power control register |
| reg_wdata | input | 8 | Write data for the power control register |
| irq_req | input | N_IRQ | Interrupt request lines |
| irq_en | input | N_IRQ | Interrupt enable bits, one per request |
| reg_rdata | output | 8 | Power control register contents |
| mode_state | output | 3 | One-hot mode: bit 0 running, bit 1 idle, bit 2 power-down |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| ram_wr_block | output | 1 | Internal RAM write inhibit |
| core_rst | output | 1 | Internal reset to the core and SFRs |

## Verification
If the decoded mode is wrong, the clock enables and `mode_state` show it on the very next edge. If a wake-up is wrongly accepted or missed, the mode bits change, or fail to change, one cycle after the request. Faults in the two delay counters show up only in how long a pulse lasts. The bench therefore counts, cycle by cycle, how long `ram_wr_block` and `core_rst` stay high and compares the counts with exact figures: 24 cycles for the window, and the larger of the reset length and the settling count. A register that is not cleared is caught by reading back 0x00 on the first cycle after release.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    localparam int IDLE_BIT = 0;
    localparam int PD_BIT   = 1;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_IDLE  = 2'd1,
        MODE_PDOWN = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        PH_NONE  = 2'd0,
        PH_GUARD = 2'd1,
        PH_HOLD  = 2'd2
    } phase_e;

endpackage

// File: rtl/pmc_delay_ctr.sv
module pmc_delay_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = load_val;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign zero = (st_q.cnt == '0);

endmodule

// File: rtl/pmc_ctl_reg.sv
module pmc_ctl_reg (
    input  logic       clk,
    input  logic       clr,
    input  logic       idle_clr,
    input  logic       we,
    input  logic [7:0] wdata,
    output logic [7:0] rdata
);
    import pmc_pkg::*;

    typedef struct packed {
        logic [7:0] val;
    } reg_t;

    reg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.val = 8'h00;
        end else if (idle_clr) begin
            st_d.val[IDLE_BIT] = 1'b0;
        end else if (we) begin
            st_d.val = wdata;
            // power-down overrides an idle request in the same write
            if (wdata[PD_BIT]) begin
                st_d.val[IDLE_BIT] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rdata = st_q.val;

endmodule

// File: rtl/pmc_seq.sv
module pmc_seq #(
    parameter int GW       = 5,
    parameter int OW       = 9,
    parameter int GUARD_CYC = 24,
    parameter int OSC_WAIT = 256
) (
    input  logic              clk,
    input  logic              hw_rst,
    input  pmc_pkg::mode_e    mode,
    input  logic              wake,
    input  logic              wr_req,
    input  logic              guard_zero,
    input  logic              osc_zero,
    output pmc_pkg::phase_e   phase,
    output logic              guard_load,
    output logic [GW-1:0]     guard_val,
    output logic              osc_load,
    output logic [OW-1:0]     osc_val,
    output logic              idle_clr,
    output logic              reg_clr,
    output logic              reg_we
);
    import pmc_pkg::*;

    typedef struct packed {
        phase_e ph;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        guard_load = 1'b0;
        guard_val  = GW'(GUARD_CYC - 1);
        osc_load   = 1'b0;
        osc_val    = '0;
        idle_clr   = 1'b0;
        unique case (st_q.ph)
            PH_NONE: begin
                if (hw_rst) begin
                    if (mode == MODE_IDLE) begin
                        st_d.ph    = PH_GUARD;
                        guard_load = 1'b1;
                        osc_load   = 1'b1;
                        idle_clr   = 1'b1;
                    end else begin
                        st_d.ph  = PH_HOLD;
                        osc_load = 1'b1;
                        if (mode == MODE_PDOWN) begin
                            osc_val = OW'(OSC_WAIT - 1);
                        end
                    end
                end else if (mode == MODE_IDLE && wake) begin
                    idle_clr = 1'b1;
                end
            end
            PH_GUARD: begin
                if (guard_zero) begin
                    st_d.ph = PH_HOLD;
                end
            end
            PH_HOLD: begin
                if (!hw_rst && osc_zero) begin
                    st_d.ph = PH_NONE;
                end
            end
            default: st_d.ph = PH_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign phase   = st_q.ph;
    assign reg_clr = (st_d.ph == PH_HOLD);
    assign reg_we  = wr_req && (st_q.ph == PH_NONE) && (st_d.ph == PH_NONE)
                     && (mode == MODE_RUN);

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
    parameter int N_IRQ      = 5,
    parameter int CLK_PER_MC = 12,
    parameter int GUARD_MC   = 2,
    parameter int OSC_WAIT   = 256
) (
    input  logic             clk,
    input  logic             hw_rst,
    input  logic             reg_wr,
    input  logic [7:0]       reg_wdata,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    output logic [7:0]       reg_rdata,
    output logic [2:0]       mode_state,
    output logic             cpu_clk_en,
    output logic             periph_clk_en,
    output logic             osc_en,
    output logic             ram_wr_block,
    output logic             core_rst
);
    import pmc_pkg::*;

    localparam int GUARD_CYC = CLK_PER_MC * GUARD_MC;
    localparam int GW        = $clog2(GUARD_CYC + 1);
    localparam int OW        = $clog2(OSC_WAIT + 1);

    mode_e          mode;
    phase_e         phase;
    logic           wake;
    logic           guard_load, osc_load, guard_zero, osc_zero;
    logic [GW-1:0]  guard_val;
    logic [OW-1:0]  osc_val;
    logic           idle_clr, reg_clr, reg_we;

    assign wake = |(irq_req & irq_en);

    always_comb begin
        if (reg_rdata[PD_BIT]) begin
            mode = MODE_PDOWN;
        end else if (reg_rdata[IDLE_BIT]) begin
            mode = MODE_IDLE;
        end else begin
            mode = MODE_RUN;
        end
    end

    pmc_ctl_reg u_reg (
        .clk      (clk),
        .clr      (reg_clr),
        .idle_clr (idle_clr),
        .we       (reg_we),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata)
    );

    pmc_seq #(
        .GW        (GW),
        .OW        (OW),
        .GUARD_CYC (GUARD_CYC),
        .OSC_WAIT  (OSC_WAIT)
    ) u_seq (
        .clk        (clk),
        .hw_rst     (hw_rst),
        .mode       (mode),
        .wake       (wake),
        .wr_req     (reg_wr),
        .guard_zero (guard_zero),
        .osc_zero   (osc_zero),
        .phase      (phase),
        .guard_load (guard_load),
        .guard_val  (guard_val),
        .osc_load   (osc_load),
        .osc_val    (osc_val),
        .idle_clr   (idle_clr),
        .reg_clr    (reg_clr),
        .reg_we     (reg_we)
    );

    pmc_delay_ctr #(.W(GW)) u_guard_ctr (
        .clk      (clk),
        .load     (guard_load),
        .load_val (guard_val),
        .zero     (guard_zero)
    );

    pmc_delay_ctr #(.W(OW)) u_osc_ctr (
        .clk      (clk),
        .load     (osc_load),
        .load_val (osc_val),
        .zero     (osc_zero)
    );

    always_comb begin
        mode_state    = 3'b000;
        mode_state[0] = (mode == MODE_RUN);
        mode_state[1] = (mode == MODE_IDLE);
        mode_state[2] = (mode == MODE_PDOWN);
        cpu_clk_en    = (mode == MODE_RUN);
        periph_clk_en = (mode != MODE_PDOWN);
        osc_en        = (mode != MODE_PDOWN);
        ram_wr_block  = (phase == PH_GUARD);
        core_rst      = (phase == PH_HOLD);
    end

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
    parameter int GUARD_CYC = 24
) (
    input logic       clk,
    input logic       hw_rst,
    input logic [7:0] reg_rdata,
    input logic [2:0] mode_state,
    input logic       cpu_clk_en,
    input logic       periph_clk_en,
    input logic       osc_en,
    input logic       ram_wr_block,
    input logic       core_rst
);
    localparam int CW = $clog2(GUARD_CYC + 2);

    logic          seen_q  = 1'b0;
    logic          armed_q = 1'b0;
    logic [CW-1:0] win_q   = '0;

    always_ff @(posedge clk) begin
        if (core_rst) seen_q <= 1'b1;
        armed_q <= seen_q;
        win_q   <= ram_wr_block ? win_q + 1'b1 : '0;
    end

    assert_onehot_R11: assert property (@(posedge clk) disable iff (!armed_q)
        $onehot(mode_state));

    assert_idle_clocks_R2: assert property (@(posedge clk) disable iff (!armed_q)
        mode_state[1] |-> (!cpu_clk_en && periph_clk_en && osc_en));

    assert_pdown_off_R3: assert property (@(posedge clk) disable iff (!armed_q)
        mode_state[2] |-> (!cpu_clk_en && !periph_clk_en && !osc_en));

    assert_pd_wins_R4: assert property (@(posedge clk) disable iff (!armed_q)
        reg_rdata[1] |-> !reg_rdata[0]);

    assert_pdown_sticky_R6: assert property (@(posedge clk) disable iff (!armed_q)
        (mode_state[2] && !hw_rst) |=> mode_state[2]);

    assert_window_cpu_R7: assert property (@(posedge clk) disable iff (!armed_q)
        ram_wr_block |-> (cpu_clk_en && !core_rst));

    assert_window_handoff_R7: assert property (@(posedge clk) disable iff (!armed_q)
        $fell(ram_wr_block) |-> core_rst);

    assert_window_len_R7: assert property (@(posedge clk) disable iff (!armed_q)
        ram_wr_block |-> (win_q < CW'(GUARD_CYC)));

    assert_hold_while_rst_R8: assert property (@(posedge clk) disable iff (!armed_q)
        (core_rst && hw_rst) |=> core_rst);

endmodule

bind pwr_mode_ctrl pmc_checker #(.GUARD_CYC(GUARD_CYC)) u_chk (
    .clk           (clk),
    .hw_rst        (hw_rst),
    .reg_rdata     (reg_rdata),
    .mode_state    (mode_state),
    .cpu_clk_en    (cpu_clk_en),
    .periph_clk_en (periph_clk_en),
    .osc_en        (osc_en),
    .ram_wr_block  (ram_wr_block),
    .core_rst      (core_rst)
);

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;

    localparam int N_IRQ = 5;
    localparam int OSC_W = 40;
    localparam int GUARD = 24;

    logic             clk = 1'b0;
    logic             hw_rst = 1'b1;
    logic             reg_wr = 1'b0;
    logic [7:0]       reg_wdata = 8'h00;
    logic [N_IRQ-1:0] irq_req = '0;
    logic [N_IRQ-1:0] irq_en = '0;
    logic [7:0]       reg_rdata;
    logic [2:0]       mode_state;
    logic             cpu_clk_en, periph_clk_en, osc_en, ram_wr_block, core_rst;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwr_mode_ctrl #(.N_IRQ(N_IRQ), .CLK_PER_MC(12), .GUARD_MC(2), .OSC_WAIT(OSC_W)) u0 (
        .clk(clk), .hw_rst(hw_rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .irq_req(irq_req), .irq_en(irq_en), .reg_rdata(reg_rdata),
        .mode_state(mode_state), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
        .osc_en(osc_en), .ram_wr_block(ram_wr_block), .core_rst(core_rst)
    );

    typedef struct packed {
        logic       op;     // 0 register write, 1 interrupt pulse
        logic [7:0] dat;
        logic [4:0] req;
        logic [4:0] en;
        logic [2:0] st;
        logic [7:0] rd;
        logic [2:0] ens;    // {cpu, periph, osc}
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h01, 5'h00, 5'h00, 3'b010, 8'h01, 3'b011},  // R2
        '{1'b1, 8'h00, 5'h04, 5'h00, 3'b010, 8'h01, 3'b011},  // R5 masked
        '{1'b1, 8'h00, 5'h04, 5'h04, 3'b001, 8'h00, 3'b111},  // R5 wake
        '{1'b0, 8'hA4, 5'h00, 5'h00, 3'b001, 8'hA4, 3'b111},  // R10
        '{1'b0, 8'hA5, 5'h00, 5'h00, 3'b010, 8'hA5, 3'b011},  // R2 R10
        '{1'b1, 8'h00, 5'h10, 5'h1F, 3'b001, 8'hA4, 3'b111},  // R5 wake
        '{1'b0, 8'h00, 5'h00, 5'h00, 3'b001, 8'h00, 3'b111}   // R10
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic irq(input logic [4:0] r, input logic [4:0] e);
        @(negedge clk);
        irq_req = r; irq_en = e;
        @(posedge clk);
        @(negedge clk);
        irq_req = '0; irq_en = '0;
    endtask

    // assert hw_rst for h edges, then count core_rst high samples
    task automatic rst_pulse(input int h, output int cnt);
        @(negedge clk);
        hw_rst = 1'b1;
        cnt = 0;
        for (int i = 0; i < h; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (core_rst) cnt++;
        end
        hw_rst = 1'b0;
        while (core_rst && cnt < 100000) begin
            @(posedge clk);
            @(negedge clk);
            if (core_rst) cnt++;
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int cnt;
        // R1: power-on style reset from run
        hw_rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 core_rst during reset", core_rst, 1);
        chk("R1 reg cleared", reg_rdata, 8'h00);
        chk("R1 mode run", mode_state, 3'b001);
        hw_rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 release after hw_rst low", core_rst, 0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            if (VEC[v].op) irq(VEC[v].req, VEC[v].en);
            else           wr(VEC[v].dat);
            chk($sformatf("R2/R5/R10 row %0d state", v), mode_state, VEC[v].st);
            chk($sformatf("R2/R5/R10 row %0d rdata", v), reg_rdata, VEC[v].rd);
            chk($sformatf("R2/R5 row %0d enables", v),
                {cpu_clk_en, periph_clk_en, osc_en}, VEC[v].ens);
        end

        // R1: reset from run lasts exactly as long as hw_rst
        rst_pulse(3, cnt);
        chk("R1 core_rst length from run", cnt, 3);

        // R4 / R3: both bits in one write
        wr(8'h03);
        chk("R4 pd wins state", mode_state, 3'b100);
        chk("R4 idle bit stored clear", reg_rdata, 8'h02);
        chk("R3 enables off", {cpu_clk_en, periph_clk_en, osc_en}, 3'b000);

        // R6: enabled interrupt ignored in power-down
        irq(5'h1F, 5'h1F);
        chk("R6 stays in power-down", mode_state, 3'b100);
        // R9: write ignored in power-down
        wr(8'h00);
        chk("R9 write ignored in power-down", reg_rdata, 8'h02);

        // R8: short reset from power-down, settling count dominates
        @(negedge clk);
        hw_rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R8 osc restarts", osc_en, 1);
        chk("R8 core_rst asserted", core_rst, 1);
        hw_rst = 1'b0;
        cnt = 1;
        reg_wr = 1'b1; reg_wdata = 8'h01;   // R9: write during hold
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        if (core_rst) cnt++;
        while (core_rst && cnt < 100000) begin
            @(posedge clk);
            @(negedge clk);
            if (core_rst) cnt++;
        end
        chk("R8 settle length short reset", cnt, OSC_W);
        chk("R9 write ignored during core_rst", reg_rdata, 8'h00);

        // R8: long reset from power-down, reset length dominates
        wr(8'h02);
        chk("R3 power-down entered again", mode_state, 3'b100);
        rst_pulse(OSC_W + 10, cnt);
        chk("R8 settle length long reset", cnt, OSC_W + 10);

        // R7: reset in idle opens the RAM write window
        wr(8'h01);
        chk("R2 idle entered", mode_state, 3'b010);
        @(negedge clk);
        hw_rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        hw_rst = 1'b0;
        chk("R7 window cpu runs", {ram_wr_block, cpu_clk_en, core_rst}, 3'b110);
        cnt = 1;
        reg_wr = 1'b1; reg_wdata = 8'h80;   // R9: write during window
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        if (ram_wr_block) cnt++;
        while (ram_wr_block && cnt < 100000) begin
            @(posedge clk);
            @(negedge clk);
            if (ram_wr_block) cnt++;
        end
        chk("R7 window length", cnt, GUARD);
        chk("R7 core_rst at window end", core_rst, 1);
        @(posedge clk);
        @(negedge clk);
        chk("R7 core_rst released", core_rst, 0);
        chk("R9 write ignored during window", reg_rdata, 8'h00);
        chk("R11 mode run after window", mode_state, 3'b001);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule